// File: doc/BRIEF.md
# Cascaded Prescaler Pulse Generator

This block holds two 8-bit down-counting pulse channels joined in a chain. The first channel, the prescaler, counts single-cycle ticks from a system-clock divider whose ratio is 1, 2, 4 or 8. It produces a pulse train whose period and high time are set by its cycle and duty inputs. Every rising and every falling edge of that train becomes one count tick for the second channel. The second channel drives the final output. Both waveforms leave the block on pins, and each pin has its own polarity control.

Each channel starts when its enable goes high. At that point it captures its cycle and duty settings and counts down once per tick. After the tick on which the count is 1, the next tick reloads the count, and new settings are taken up only at that reload. The output chain advances only while the prescaler output actually toggles. A stopped prescaler, or one held at a 0% or 100% duty, therefore freezes the second channel.

Top module: `cascade_pwm`

## Requirements
- R1: When a channel's enable rises, the channel captures its cycle and duty values in that clock edge. With a duty at or above the cycle, its pin is at the active level one cycle after the enable is sampled high.
- R2: A running channel repeats a count of cycle, cycle-1, ..., 1. Its raw output is high while the count is at or below the duty value. The period is therefore cycle ticks and the high time is duty ticks.
- R3: The prescaler tick occurs every 2^div_sel system clocks. The encodings are div_sel 0 = 1 clock, 1 = 2, 2 = 4 and 3 = 8.
- R4: Each pin equals the raw output XOR its invert input. An invert value of 1 gives the complementary waveform.
- R5: A low enable stops the channel and forces its raw output low from the next cycle, so its pin shows the invert level.
- R6: The output channel receives one tick for every rising and every falling edge of the prescaler's raw output. For even output cycle and duty values, the output period is (cycle/2) prescaler periods and the output high time is (duty/2) prescaler periods. This holds whatever the prescaler invert setting is.
- R7: While the prescaler is disabled, the output channel does not count and its pin holds its level.
- R8: A duty of 0 gives a constantly low raw output. A duty at or above the cycle gives a constantly high raw output. A constant prescaler output gives the output channel no ticks.
- R9: Changes to cycle or duty while a channel runs take effect only at that channel's next reload.
- R10: After reset both channels are idle and both pins equal their invert inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_sel | input | 2 | Prescaler tick divide select (1, 2, 4, 8) |
| pre_en | input | 1 | Prescaler channel enable |
| pre_inv | input | 1 | Prescaler pin invert |
| pre_cycle | input | 8 | Prescaler cycle value in ticks |
| pre_duty | input | 8 | Prescaler duty value in ticks |
| out_en | input | 1 | Output channel enable |
| out_inv | input | 1 | Output pin invert |
| out_cycle | input | 8 | Output cycle value in prescaler edges |
| out_duty | input | 8 | Output duty value in prescaler edges |
| pre_pin | output | 1 | Prescaler waveform after polarity |
| out_pin | output | 1 | Output waveform after polarity |

## Verification
A wrong down-counter or a wrong captured duty in either channel shows up at the pins within one period of that channel. It appears as a high time or period that differs from the cycle and duty product, so timing both pins across several divider settings exposes it. A faulty edge detector shows up as a change in the output period relative to the prescaler period. The output period doubles or halves if edges are missed or counted twice, and it jumps when only the polarity changes. A stall that leaks, or an update taken before the reload, shows up in the first pulse after the stimulus.

// File: rtl/cascade_pwm_pkg.sv
// Package: shared widths and the divider select encoding for the cascaded
// pulse generator. Assumes 8-bit channels and a 2-bit divider select.
package cascade_pwm_pkg;
    localparam int CH_W      = 8;
    localparam int DIV_SEL_W = 2;

    typedef enum logic [DIV_SEL_W-1:0] {
        DIV_BY_1 = 2'd0,
        DIV_BY_2 = 2'd1,
        DIV_BY_4 = 2'd2,
        DIV_BY_8 = 2'd3
    } div_sel_e;
endpackage

// File: rtl/tick_divider.sv
// Module: tick_divider
// Produces a one-cycle tick every 2^sel system clocks from a free-running
// counter. Assumes sel changes rarely; a change takes effect on the next
// counter alignment.
module tick_divider #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_o
);
    localparam int MAX_LOG = (1 << SEL_W) - 1;
    localparam int CNT_W   = (MAX_LOG > 0) ? MAX_LOG : 1;

    logic [CNT_W-1:0] div_cnt;
    logic [CNT_W-1:0] mask;
    logic             tick_q;

    // Build the low-bit mask selected by sel.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            mask[i] = (i < int'(sel));
        end
    end

    // Free-running counter and registered tick when masked bits are all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            tick_q  <= 1'b0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
            tick_q  <= ((div_cnt & mask) == mask);
        end
    end

    assign tick_o = tick_q;

    // R3: with divide-by-one held, a tick is present on every cycle after reset.
    assert_div1_every_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0 && $past(sel) == '0 && $past(rst_n)) |-> tick_o);
endmodule

// File: rtl/pwm_channel.sv
// Module: pwm_channel
// One down-counting pulse channel. On enable it captures cycle and duty,
// then counts one step per tick and reloads after the tick at count 1.
// The raw output is high while the count is at or below the captured duty.
// Assumes tick is a single-cycle strobe in the clk domain.
module pwm_channel #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en,
    input  logic [W-1:0] cycle,
    input  logic [W-1:0] duty,
    output logic         raw_o
);
    logic         run;
    logic [W-1:0] cnt;
    logic [W-1:0] duty_q;

    // Start, count, reload and stop sequencing of the channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            cnt    <= '0;
            duty_q <= '0;
        end else if (!en) begin
            run <= 1'b0;
        end else if (!run) begin
            run    <= 1'b1;
            cnt    <= cycle;
            duty_q <= duty;
        end else if (tick) begin
            if (cnt <= W'(1)) begin
                cnt    <= cycle;
                duty_q <= duty;
            end else begin
                cnt <= cnt - W'(1);
            end
        end
    end

    // Duty compare against the captured duty value.
    always_comb begin
        raw_o = run && (duty_q != '0) && (cnt <= duty_q);
    end

    // R5: a low enable forces the raw output low on the next cycle.
    assert_stop_forces_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !raw_o);

    // R7: without a tick the running count holds its value.
    assert_hold_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en && !tick) |=> $stable(cnt));

    // R2: a tick above count 1 steps the count down by exactly one.
    assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en && tick && cnt > W'(1)) |=> (cnt == $past(cnt) - W'(1)));
endmodule

// File: rtl/edge_tick.sv
// Module: edge_tick
// Turns every rising and falling edge of a level into a one-cycle tick,
// using a registered copy of the level. Assumes the level is synchronous
// to clk; the copy resets low, matching an idle channel.
module edge_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic tick_o
);
    logic prev_q;

    // Hold last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level_i;
        end
    end

    assign tick_o = level_i ^ prev_q;
endmodule

// File: rtl/cascade_pwm.sv
// Module: cascade_pwm
// Top of the cascaded pulse generator: divider -> prescaler channel ->
// edge tick -> output channel. Pins apply polarity to each raw waveform.
// Assumes all inputs are synchronous to clk.
module cascade_pwm
    import cascade_pwm_pkg::*;
#(
    parameter int W     = CH_W,
    parameter int SEL_W = DIV_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             pre_en,
    input  logic             pre_inv,
    input  logic [W-1:0]     pre_cycle,
    input  logic [W-1:0]     pre_duty,
    input  logic             out_en,
    input  logic             out_inv,
    input  logic [W-1:0]     out_cycle,
    input  logic [W-1:0]     out_duty,
    output logic             pre_pin,
    output logic             out_pin
);
    logic pre_tick;
    logic pre_raw;
    logic out_tick;
    logic out_raw;

    tick_divider #(.SEL_W(SEL_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (div_sel),
        .tick_o (pre_tick)
    );

    pwm_channel #(.W(W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (pre_tick),
        .en    (pre_en),
        .cycle (pre_cycle),
        .duty  (pre_duty),
        .raw_o (pre_raw)
    );

    edge_tick u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pre_raw),
        .tick_o  (out_tick)
    );

    pwm_channel #(.W(W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (out_tick),
        .en    (out_en),
        .cycle (out_cycle),
        .duty  (out_duty),
        .raw_o (out_raw)
    );

    // Polarity stage for both pins.
    always_comb begin
        pre_pin = pre_raw ^ pre_inv;
        out_pin = out_raw ^ out_inv;
    end

    // R7: once the prescaler has been off for two cycles, no output tick occurs.
    assert_stall_when_pre_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_en && $past(!pre_en) && $past(!pre_en, 2)) |-> !out_tick);
endmodule

// File: tb/sim_cascade_pwm.sv
module sim_cascade_pwm;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] div_sel;
    logic       pre_en, pre_inv, out_en, out_inv;
    logic [7:0] pre_cycle, pre_duty, out_cycle, out_duty;
    logic       pre_pin, out_pin;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    cascade_pwm u0 (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel),
        .pre_en(pre_en), .pre_inv(pre_inv), .pre_cycle(pre_cycle), .pre_duty(pre_duty),
        .out_en(out_en), .out_inv(out_inv), .out_cycle(out_cycle), .out_duty(out_duty),
        .pre_pin(pre_pin), .out_pin(out_pin)
    );

    // sel, pre_cycle, pre_duty, out_cycle, out_duty, pre_per, pre_hi, out_per, out_hi
    localparam int NV = 5;
    localparam int VEC [NV][9] = '{
        '{0, 4, 2,  4, 2,  4, 2,  8,  4},
        '{1, 5, 2,  6, 2, 10, 4, 30, 10},
        '{2, 3, 1,  4, 2, 12, 4, 24, 12},
        '{3, 2, 1,  8, 6, 16, 8, 64, 48},
        '{0, 6, 3, 10, 4,  6, 3, 30, 12}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pin_of(input bit which);
        return which ? out_pin : pre_pin;
    endfunction

    task automatic wait_rise(input bit which);
        logic last;
        last = pin_of(which);
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (!last && pin_of(which)) return;
            last = pin_of(which);
        end
    endtask

    task automatic run_width(input bit which, input logic lvl, output int n);
        n = 0;
        while (pin_of(which) == lvl && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure(input bit which, output int hi, output int per);
        int lo;
        wait_rise(which);
        run_width(which, 1'b1, hi);
        run_width(which, 1'b0, lo);
        per = hi + lo;
    endtask

    task automatic idle_all();
        @(negedge clk);
        pre_en = 1'b0; out_en = 1'b0; pre_inv = 1'b0; out_inv = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int hi, per, stuck;
        rst_n = 1'b0; div_sel = 2'd0;
        pre_en = 1'b0; pre_inv = 1'b0; out_en = 1'b0; out_inv = 1'b0;
        pre_cycle = 8'd4; pre_duty = 8'd2; out_cycle = 8'd4; out_duty = 8'd2;
        repeat (4) @(negedge clk);
        check(pre_pin == 1'b0 && out_pin == 1'b0, "R10 reset pins", {pre_pin, out_pin}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pre_pin == 1'b0 && out_pin == 1'b0, "R10 idle after reset", {pre_pin, out_pin}, 0);

        // Table walk: R2, R3, R6 across divider settings.
        for (int v = 0; v < NV; v++) begin
            idle_all();
            div_sel = 2'(VEC[v][0]);
            pre_cycle = 8'(VEC[v][1]); pre_duty = 8'(VEC[v][2]);
            out_cycle = 8'(VEC[v][3]); out_duty = 8'(VEC[v][4]);
            @(negedge clk);
            pre_en = 1'b1; out_en = 1'b1;
            measure(1'b0, hi, per);
            check(per == VEC[v][5], "R3 prescaler period", per, VEC[v][5]);
            check(hi == VEC[v][6], "R2 prescaler high time", hi, VEC[v][6]);
            measure(1'b1, hi, per);
            check(per == VEC[v][7], "R6 output period", per, VEC[v][7]);
            check(hi == VEC[v][8], "R6 output high time", hi, VEC[v][8]);
        end

        // R4 and R6: inverted pins, output timing unaffected by prescaler polarity.
        idle_all();
        div_sel = 2'd1; pre_cycle = 8'd5; pre_duty = 8'd2; out_cycle = 8'd6; out_duty = 8'd2;
        pre_inv = 1'b1; out_inv = 1'b1;
        @(negedge clk);
        check(pre_pin == 1'b1 && out_pin == 1'b1, "R4 idle inverted pins", {pre_pin, out_pin}, 3);
        pre_en = 1'b1; out_en = 1'b1;
        measure(1'b0, hi, per);
        check(hi == 6 && per == 10, "R4 inverted prescaler high", hi, 6);
        measure(1'b1, hi, per);
        check(hi == 20, "R4 inverted output high", hi, 20);
        check(per == 30, "R6 period with prescaler inverted", per, 30);

        // R5: disable forces raw low, pin follows invert level.
        @(negedge clk);
        pre_en = 1'b0; out_en = 1'b0; pre_inv = 1'b1; out_inv = 1'b0;
        @(negedge clk);
        stuck = 0;
        for (int k = 0; k < 20; k++) begin
            if (pre_pin != 1'b1 || out_pin != 1'b0) stuck++;
            @(negedge clk);
        end
        check(stuck == 0, "R5 disabled pins hold invert level", stuck, 0);

        // R1: enable captures values; duty >= cycle goes active after one edge.
        idle_all();
        div_sel = 2'd3; pre_cycle = 8'd5; pre_duty = 8'd9;
        @(negedge clk);
        check(pre_pin == 1'b0, "R1 before enable", pre_pin, 0);
        pre_en = 1'b1;
        @(negedge clk);
        check(pre_pin == 1'b1, "R1 active one cycle after enable", pre_pin, 1);

        // R8: constant high prescaler gives the output no progress.
        out_cycle = 8'd4; out_duty = 8'd2; out_en = 1'b1;
        stuck = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (pre_pin != 1'b1 || out_pin != 1'b0) stuck++;
        end
        check(stuck == 0, "R8 full duty constant, output stalled", stuck, 0);

        // R8: zero duty is constantly low.
        idle_all();
        div_sel = 2'd0; pre_cycle = 8'd4; pre_duty = 8'd0; out_cycle = 8'd2; out_duty = 8'd1;
        @(negedge clk);
        pre_en = 1'b1; out_en = 1'b1;
        stuck = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (pre_pin != 1'b0 || out_pin != 1'b0) stuck++;
        end
        check(stuck == 0, "R8 zero duty constant low", stuck, 0);

        // R7: output enabled with prescaler stopped never advances.
        idle_all();
        pre_cycle = 8'd2; pre_duty = 8'd1; out_cycle = 8'd3; out_duty = 8'd2;
        @(negedge clk);
        out_en = 1'b1;
        stuck = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (out_pin != 1'b0) stuck++;
        end
        check(stuck == 0, "R7 output holds with prescaler off", stuck, 0);
        // Output reaches duty after one prescaler edge once started: count 3 -> 2.
        pre_en = 1'b1;
        wait_rise(1'b1);
        check(out_pin == 1'b1, "R7 output resumes once prescaler runs", out_pin, 1);

        // R9: duty change mid-period applies only after reload.
        idle_all();
        div_sel = 2'd0; pre_cycle = 8'd8; pre_duty = 8'd2;
        @(negedge clk);
        pre_en = 1'b1;
        wait_rise(1'b0);
        pre_duty = 8'd6;
        run_width(1'b0, 1'b1, hi);
        check(hi == 2, "R9 current pulse keeps old duty", hi, 2);
        wait_rise(1'b0);
        run_width(1'b0, 1'b1, hi);
        check(hi == 6, "R9 new duty after reload", hi, 6);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule